// File: doc/BRIEF.md
# Periodic USB Transaction Bus-Time Calculator

This block works out how many bytes of bus time one periodic USB transaction will use. A bandwidth-allocation engine gives it the device speed, the transfer kind (interrupt or isochronous), the direction, whether the transaction is split through a hub translator, the maximum packet size, and the number of high-speed transactions per microframe. It returns a total byte cost. For split transactions it also returns separate costs for the start-split phase and the complete-split phase, so the caller can charge each phase to its own microframes.

All costs start from a worst-case payload term: the packet size times 7, divided by 6, with the remainder dropped. This term covers bit stuffing. Each speed then adds its own protocol overhead and a fixed host delay of 18 bytes. Low-speed payloads are stretched eightfold. A high-speed non-split cost is multiplied by the number of transactions per microframe. A split transaction is priced on the high-speed bus, and the payload term goes to only one of its two phases, chosen by direction.

A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. The result sits in a register and appears on the following cycle. The result is held until the consumer takes it.

Top module: `usb_xact_cost`

## Requirements
- R1: Full speed (`speed` = 2'b00) without split: cost = P + 18 + H. P is floor(mps*7/6). H is 14 for interrupt, 10 for isochronous OUT and 11 for isochronous IN.
- R2: Low speed (`speed` = 2'b01) without split: cost = 97 + 1 + 18 + 8*P.
- R3: High speed (`speed[1]` = 1): cost = (G + P + 18) * N. G is 55 for interrupt and 38 for isochronous. N is `xfers`, and an `xfers` value of 0 is treated as 1.
- R4: A split transaction with `dir_in` = 1 (device to host), for full or low speed: start cost = G + 18 + 4, complete cost = G + 18 + 4 + P, total cost = start + complete.
- R5: A split transaction with `dir_in` = 0 (host to device), for full or low speed: start cost = G + 18 + 4 + P, complete cost = G + 18 + 4, total cost = start + complete.
- R6: Without split, both phase costs are 0. When `speed[1]` = 1, the `split` input has no effect. For full or low speed split requests, `xfers` has no effect.
- R7: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `res_valid` rises on that edge, and the result belongs to that request. `req_ready` equals !`res_valid` || `res_ready`.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and all three cost outputs stay unchanged.
- R9: After reset, `res_valid` is 0 and all cost outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| speed | input | 2 | 00 full, 01 low, 1x high |
| iso | input | 1 | 1 isochronous, 0 interrupt |
| dir_in | input | 1 | 1 device to host, 0 host to device |
| split | input | 1 | Transaction goes through a hub translator |
| mps | input | 11 | Maximum packet size in bytes |
| xfers | input | 2 | High-speed transactions per microframe (0 counts as 1) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| cost | output | 16 | Total bus time in bytes |
| ss_cost | output | 16 | Start-split bytes, 0 if not split |
| cs_cost | output | 16 | Complete-split bytes, 0 if not split |

## Verification
Every combination of the speed code, transfer kind, direction and split flag is run. Each combination is tried with packet sizes of 0, 1, 5, 8, 64, 1023 and 2047, and with transaction counts 0 to 3. Sizes that are not multiples of six check that the division truncates. The largest size at low speed checks that the eightfold term still fits in 16 bits. Count 0 next to 1 checks the lower clamp of the multiplier. The split runs at high speed check that the split flag is ignored there, and the direction sweep checks which phase receives the payload. Throughout, the consumer withholds `res_ready` on an irregular pattern, which checks that results are held and that none are lost or repeated.

// File: rtl/usb_xact_cost.sv
module usb_xact_cost #(
  parameter int MPS_W    = 11,
  parameter int CNT_W    = 16,
  parameter int HOST_DLY = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       speed,
  input  logic             iso,
  input  logic             dir_in,
  input  logic             split,
  input  logic [MPS_W-1:0] mps,
  input  logic [1:0]       xfers,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] cost,
  output logic [CNT_W-1:0] ss_cost,
  output logic [CNT_W-1:0] cs_cost
);
  localparam logic [CNT_W-1:0] HDLY    = CNT_W'(HOST_DLY);
  localparam logic [CNT_W-1:0] FS_INT  = CNT_W'(14);
  localparam logic [CNT_W-1:0] FS_ISO_O = CNT_W'(10);
  localparam logic [CNT_W-1:0] FS_ISO_I = CNT_W'(11);
  localparam logic [CNT_W-1:0] LS_FIX  = CNT_W'(97 + 1 + HOST_DLY);
  localparam logic [CNT_W-1:0] HS_INT  = CNT_W'(55);
  localparam logic [CNT_W-1:0] HS_ISO  = CNT_W'(38);
  localparam logic [CNT_W-1:0] SPL_OVH = CNT_W'(4);

  logic [MPS_W+2:0] mps7;
  logic [CNT_W-1:0] stuffed, hs_ovh, fs_ovh, base, n_eff;
  logic [CNT_W-1:0] c_cost, c_ss, c_cs;
  logic             is_hs, is_ls, do_split, accept;

  assign mps7     = ({3'b000, mps} << 3) - {3'b000, mps};
  assign stuffed  = CNT_W'(mps7 / 6);
  assign is_hs    = speed[1];
  assign is_ls    = !speed[1] && speed[0];
  assign do_split = split && !is_hs;
  assign hs_ovh   = iso ? HS_ISO : HS_INT;
  assign fs_ovh   = !iso ? FS_INT : (dir_in ? FS_ISO_I : FS_ISO_O);
  assign n_eff    = (xfers == 2'd0) ? CNT_W'(1) : CNT_W'(xfers);
  assign base     = hs_ovh + HDLY + SPL_OVH;

  always_comb begin
    c_ss   = '0;
    c_cs   = '0;
    c_cost = '0;
    if (do_split) begin
      c_ss   = dir_in ? base : base + stuffed;
      c_cs   = dir_in ? base + stuffed : base;
      c_cost = c_ss + c_cs;
    end else if (is_hs) begin
      c_cost = (hs_ovh + stuffed + HDLY) * n_eff;
    end else if (is_ls) begin
      c_cost = LS_FIX + (stuffed << 3);
    end else begin
      c_cost = fs_ovh + stuffed + HDLY;
    end
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cost      <= '0;
      ss_cost   <= '0;
      cs_cost   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      cost      <= c_cost;
      ss_cost   <= c_ss;
      cs_cost   <= c_cs;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R7: an accepted request yields a result on the next edge
  a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R7: no result is pending, so the block must accept
  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready);

  // R8: a withheld result is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(cost) && $stable(ss_cost) && $stable(cs_cost)));

  // R6: a request that is not split carries no phase costs
  a_r6_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(split && !speed[1])) |=> (ss_cost == '0 && cs_cost == '0));

  // R4/R5: each split phase includes at least the fixed overhead and host delay
  a_r4_r5_phase_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && split && !speed[1]) |=> (ss_cost >= HS_ISO + HDLY + SPL_OVH && cs_cost >= HS_ISO + HDLY + SPL_OVH));
endmodule

// File: tb/sim_usb_xact_cost.sv
module sim_usb_xact_cost;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  speed = '0;
  logic        iso = 1'b0, dir_in = 1'b0, split = 1'b0;
  logic [10:0] mps = '0;
  logic [1:0]  xfers = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] cost, ss_cost, cs_cost;

  int checks = 0;
  int errors = 0;
  bit stall_on = 1'b0;
  int tick = 0;
  bit done = 1'b0;
  logic [47:0] expq[$];

  always #5 clk = ~clk;

  usb_xact_cost u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .speed(speed), .iso(iso), .dir_in(dir_in), .split(split), .mps(mps), .xfers(xfers),
    .res_valid(res_valid), .res_ready(res_ready), .cost(cost), .ss_cost(ss_cost), .cs_cost(cs_cost));

  function automatic logic [47:0] model(input logic [1:0] sp, input logic is_o, input logic din,
                                        input logic sp_l, input int m, input int n);
    int p, g, h, b, s, c, t;
    p = (m * 7) / 6;
    g = is_o ? 38 : 55;
    h = !is_o ? 14 : (din ? 11 : 10);
    s = 0; c = 0;
    if (sp_l && !sp[1]) begin
      b = g + 18 + 4;
      s = din ? b : b + p;
      c = din ? b + p : b;
      t = s + c;
    end else if (sp[1]) t = (g + p + 18) * ((n == 0) ? 1 : n);
    else if (sp[0]) t = 116 + 8 * p;
    else t = h + p + 18;
    return {16'(t), 16'(s), 16'(c)};
  endfunction

  function automatic string tag(input logic [1:0] sp, input logic sp_l, input logic din);
    if (sp_l && !sp[1]) return din ? "R4" : "R5";
    if (sp[1]) return sp_l ? "R3/R6" : "R3";
    return sp[0] ? "R2/R6" : "R1/R6";
  endfunction

  logic [47:0] tagq_dummy;
  string tags[$];

  task automatic send(input logic [1:0] sp, input logic is_o, input logic din, input logic sp_l,
                      input int m, input int n);
    @(negedge clk);
    speed = sp; iso = is_o; dir_in = din; split = sp_l; mps = 11'(m); xfers = 2'(n);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    expq.push_back(model(sp, is_o, din, sp_l, m, n));
    tags.push_back(tag(sp, sp_l, din));
  endtask

  // consumer readiness changes away from both edges used for sampling
  always @(posedge clk) begin
    tick <= tick + 1;
    #2 res_ready = !stall_on || ((tick % 7) != 2 && (tick % 5) != 4);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R7: result without request, got %0d expected none", cost);
      end else if ({cost, ss_cost, cs_cost} !== expq[0]) begin
        errors++;
        $display("FAIL %s: got cost=%0d ss=%0d cs=%0d expected cost=%0d ss=%0d cs=%0d (held=%0b, R8)",
                 tags[0], cost, ss_cost, cs_cost, expq[0][47:32], expq[0][31:16], expq[0][15:0], !res_ready);
      end
      if (res_ready && expq.size() != 0) begin
        void'(expq.pop_front());
        void'(tags.pop_front());
      end
    end
  end

  initial begin
    int sizes[7] = '{0, 1, 5, 8, 64, 1023, 2047};
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || cost !== 16'd0 || ss_cost !== 16'd0 || cs_cost !== 16'd0) begin
      errors++;
      $display("FAIL R9: reset got valid=%0b cost=%0d ss=%0d cs=%0d expected 0 0 0 0", res_valid, cost, ss_cost, cs_cost);
    end
    rst_n = 1'b1;
    // R7 directed timing: accept at one edge, valid at the next sample
    send(2'b00, 1'b0, 1'b0, 1'b0, 64, 1);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (res_valid !== 1'b1) begin
      errors++;
      $display("FAIL R7: res_valid got %0b expected 1 one cycle after accept", res_valid);
    end
    @(negedge clk);
    stall_on = 1'b1;
    for (int sp = 0; sp < 4; sp++)
      for (int io = 0; io < 2; io++)
        for (int d = 0; d < 2; d++)
          for (int sl = 0; sl < 2; sl++)
            for (int k = 0; k < 7; k++)
              for (int n = 0; n < 4; n++)
                send(2'(sp), 1'(io), 1'(d), 1'(sl), sizes[k], n);
    @(negedge clk);
    req_valid = 1'b0;
    stall_on = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d results missing, expected 0", expq.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R7: watchdog expired, got hang expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule